// File: doc/BRIEF.md
# Triggerless Strip Hit Sparsifier

This block serves one group of binary strip discriminators, up to 100 of them. At every bunch-crossing strobe it takes a snapshot of the strip inputs and discards the strips that did not fire. No trigger is involved. Each strip that fired becomes an 11-bit hit word, and the words go out on one serial line as they arrive.

A hit word holds the strip address and a 4-bit tag. The tag identifies the crossing within a window of 16. When several strips fire in the same crossing, an iterative priority encoder queues them one per clock, lowest address first, and all of them get the same tag. A 16-word FIFO decouples the burst of hits from the line. A serializer sends each word in a 12-bit frame: a start bit followed by the word, MSB first. The bit clock is a one-cycle enable, typically asserted 12 times per crossing.

When the FIFO is full, new hits are lost. A sticky flag records that this happened, and a saturating counter records how many hits were lost.

Top module: `strip_sparsifier`

## Requirements
- R1: After a synchronous active-low reset, `ser_out`, `overflow` and `drop_count` are all 0. The first crossing after reset carries tag 0.
- R2: A crossing in which no strip is set produces no frame. Between frames the line stays at 0.
- R3: A hit word is `{addr[6:0], tag[3:0]}`: the address is in bits 10..4 and the tag in bits 3..0.
- R4: All hits from one crossing are emitted in ascending address order, and all of them carry that crossing's tag. The encoder queues one hit per clock, so the crossing period must be at least `N_STRIPS`+2 clocks.
- R5: The tag increases by 1 on each `xing_stb`, including crossings with no hits, and wraps from 15 to 0.
- R6: Inputs `strips_in[127:N_STRIPS]` are ignored, and addresses of `N_STRIPS` or above are never produced.
- R7: A frame is a start bit of 1 followed by the 11 word bits, MSB first. Each bit is held from one `bit_en` edge to the next. A new frame may follow the previous one with no gap.
- R8: Words leave in the order they were queued, across crossings. Up to 16 words are held while the line is not draining.
- R9: A hit that arrives while the FIFO is full is discarded. `overflow` then sets and stays set until reset, and `drop_count` increments by one per discarded hit, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xing_stb | input | 1 | One-cycle bunch-crossing strobe; samples the strips |
| strips_in | input | 128 | Discriminator inputs; bits at or above N_STRIPS are ignored |
| bit_en | input | 1 | Serial bit-slot enable |
| ser_out | output | 1 | Serial frame output, idle 0 |
| overflow | output | 1 | Sticky flag: at least one hit was dropped |
| drop_count | output | CNT_W | Saturating count of dropped hits |

## Verification
The hardest condition to reach from the ports is a full FIFO. At the nominal rate the line drains about one word per crossing, so the FIFO never fills on its own. The bench therefore gates `bit_en` off and applies a 30-strip crossing, which should store 16 words and drop 14. It then applies a second burst while the FIFO is still full, to push the small drop counter into saturation. Finally it re-enables the line and checks that exactly the first 16 addresses come out in order.

// File: rtl/sparsifier_pkg.sv
// Package: shared word format for the strip sparsifier.
// Assumes a group never exceeds 2**ADDR_W strips.
package sparsifier_pkg;
    localparam int ADDR_W  = 7;
    localparam int TAG_W   = 4;
    localparam int WORD_W  = ADDR_W + TAG_W;
    localparam int FRAME_W = WORD_W + 1;
    localparam int LANES   = 1 << ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
    } hit_word_t;
endpackage

// File: rtl/xing_tagger.sv
// Module: xing_tagger
// Free-running crossing counter. It advances once per crossing strobe and
// wraps modulo 2**TAG_W. Assumes the strobe is a one-cycle pulse.
module xing_tagger
    import sparsifier_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xing_stb,
    output logic [TAG_W-1:0] tag
);
    // Purpose: advance the tag on each crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)        tag <= '0;
        else if (xing_stb) tag <= tag + 1'b1;
    end
endmodule

// File: rtl/hit_priority_encoder.sv
// Module: hit_priority_encoder
// Latches the strip snapshot on a crossing strobe and masks off lanes that
// do not exist. It then emits one hit per clock, lowest address first.
// Assumes the strobe period leaves time to drain the mask (>= N_STRIPS+2).
module hit_priority_encoder
    import sparsifier_pkg::*;
#(
    parameter int N_STRIPS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xing_stb,
    input  logic [LANES-1:0] strips,
    input  logic [TAG_W-1:0] tag_in,
    output logic             push,
    output hit_word_t        word
);
    logic [LANES-1:0]  valid_mask;
    logic [LANES-1:0]  pending;
    logic [TAG_W-1:0]  tag_hold;
    logic [ADDR_W-1:0] lo_idx;

    // Lanes at or past the group size are never accepted.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign valid_mask[g] = (g < N_STRIPS) ? 1'b1 : 1'b0;
    end

    // Purpose: locate the lowest pending strip.
    always_comb begin
        lo_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) lo_idx = ADDR_W'(i);
        end
    end

    assign push      = |pending;
    assign word.addr = lo_idx;
    assign word.tag  = tag_hold;

    // Purpose: capture a new snapshot, or retire the hit just emitted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= '0;
            tag_hold <= '0;
        end else if (xing_stb) begin
            pending  <= strips & valid_mask;
            tag_hold <= tag_in;
        end else if (push) begin
            pending[lo_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/hit_fifo.sv
// Module: hit_fifo
// Data-driven hit buffer. A push while full is discarded, and the loss is
// recorded in a sticky flag and a saturating counter. Read data is valid
// whenever the FIFO is not empty.
module hit_fifo
    import sparsifier_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  hit_word_t        wr_word,
    input  logic             pop,
    output hit_word_t        rd_word,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             overflow,
    output logic [CNT_W-1:0] drop_count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    hit_word_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop, drop;

    assign empty   = (count == '0);
    assign full    = (count == DEPTH[$clog2(DEPTH+1)-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign rd_word = mem[rd_ptr];

    // Purpose: store an accepted word.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_word;
    end

    // Purpose: pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Purpose: sticky loss flag and saturating loss counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow   <= 1'b0;
            drop_count <= '0;
        end else if (drop) begin
            overflow <= 1'b1;
            if (drop_count != '1) drop_count <= drop_count + 1'b1;
        end
    end
endmodule

// File: rtl/frame_serializer.sv
// Module: frame_serializer
// Sends each word as a frame: a start bit of 1, then the word MSB first.
// The shift happens only on bit_en, and the next word is loaded in the
// slot that ends the current frame, so frames can follow with no gap.
module frame_serializer
    import sparsifier_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_en,
    input  logic      empty,
    input  hit_word_t rd_word,
    output logic      pop,
    output logic      ser_out
);
    localparam int BL_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg;
    logic [BL_W-1:0]    bits_left;
    logic               last_slot;

    assign last_slot = (bits_left <= BL_W'(1));
    assign pop       = bit_en && last_slot && !empty;
    assign ser_out   = shreg[FRAME_W-1] && (bits_left != '0);

    // Purpose: shift out the current frame or load the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
        end else if (bit_en) begin
            if (!last_slot) begin
                shreg     <= {shreg[FRAME_W-2:0], 1'b0};
                bits_left <= bits_left - 1'b1;
            end else if (!empty) begin
                shreg     <= {1'b1, rd_word};
                bits_left <= BL_W'(FRAME_W);
            end else begin
                shreg     <= '0;
                bits_left <= '0;
            end
        end
    end
endmodule

// File: rtl/strip_sparsifier.sv
// Module: strip_sparsifier (top)
// Triggerless zero-suppressing readout for one strip group:
// tagger -> priority encoder -> hit FIFO -> frame serializer.
// Assumes xing_stb pulses no more often than every N_STRIPS+2 clocks.
module strip_sparsifier
    import sparsifier_pkg::*;
#(
    parameter int N_STRIPS   = 100,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xing_stb,
    input  logic [LANES-1:0] strips_in,
    input  logic             bit_en,
    output logic             ser_out,
    output logic             overflow,
    output logic [CNT_W-1:0] drop_count
);
    localparam int FC_W = $clog2(FIFO_DEPTH + 1);

    logic [TAG_W-1:0] tag_cnt;
    logic             enc_push;
    hit_word_t        enc_word;
    hit_word_t        rd_word;
    logic             fifo_empty, fifo_full, ser_pop;
    logic [FC_W-1:0]  fifo_count;

    xing_tagger u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .xing_stb (xing_stb),
        .tag      (tag_cnt)
    );

    hit_priority_encoder #(.N_STRIPS(N_STRIPS)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .xing_stb (xing_stb),
        .strips   (strips_in),
        .tag_in   (tag_cnt),
        .push     (enc_push),
        .word     (enc_word)
    );

    hit_fifo #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (enc_push),
        .wr_word    (enc_word),
        .pop        (ser_pop),
        .rd_word    (rd_word),
        .empty      (fifo_empty),
        .full       (fifo_full),
        .count      (fifo_count),
        .overflow   (overflow),
        .drop_count (drop_count)
    );

    frame_serializer u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .empty   (fifo_empty),
        .rd_word (rd_word),
        .pop     (ser_pop),
        .ser_out (ser_out)
    );
endmodule

// File: rtl/strip_sparsifier_chk.sv
// Module: strip_sparsifier_chk
// Temporal checks on the sparsifier, bound to the top.
module strip_sparsifier_chk
    import sparsifier_pkg::*;
#(
    parameter int N_STRIPS   = 100,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           xing_stb,
    input logic                           enc_push,
    input hit_word_t                      enc_word,
    input logic [TAG_W-1:0]               tag_cnt,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
    input logic                           overflow,
    input logic [CNT_W-1:0]               drop_count
);
    assert_tag_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xing_stb |=> tag_cnt == TAG_W'($past(tag_cnt) + 1'b1));

    assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        enc_push |-> int'(enc_word.addr) < N_STRIPS);

    assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_push && $past(enc_push) && !$past(xing_stb))
            |-> (enc_word.addr > $past(enc_word.addr)) && (enc_word.tag == $past(enc_word.tag)));

    assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_count) <= FIFO_DEPTH);

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_drop_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !overflow |=> (drop_count == '0) || overflow);
endmodule

bind strip_sparsifier strip_sparsifier_chk #(
    .N_STRIPS(N_STRIPS), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xing_stb   (xing_stb),
    .enc_push   (enc_push),
    .enc_word   (enc_word),
    .tag_cnt    (tag_cnt),
    .fifo_count (fifo_count),
    .overflow   (overflow),
    .drop_count (drop_count)
);

// File: tb/tb_strip_sparsifier.sv
// Directed bench: one task per scenario. A behavioural frame receiver and
// an expected-word list built from the requirements.
module tb_strip_sparsifier;
    localparam int XPER  = 120;  // clocks per crossing
    localparam int BDIV  = 10;   // clocks per bit slot -> 12 slots/crossing
    localparam int CNT_W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         xing_stb = 1'b0;
    logic [127:0] strips_in = '0;
    logic         bit_en = 1'b0;
    logic         bit_gate = 1'b1;
    logic         ser_out, overflow;
    logic [CNT_W-1:0] drop_count;

    int vectors = 0, errors = 0;
    int exp_w [0:511];
    int rx_w  [0:511];
    int exp_n = 0, rx_n = 0, cmp_from = 0, exp_tag = 0;
    int rx_bits = 0, rx_acc = 0, div = 0;
    bit finished = 1'b0;

    strip_sparsifier #(.N_STRIPS(100), .FIFO_DEPTH(16), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .xing_stb(xing_stb), .strips_in(strips_in),
        .bit_en(bit_en), .ser_out(ser_out), .overflow(overflow), .drop_count(drop_count)
    );

    always #2.5 clk = ~clk;

    // Bit-slot enable generator.
    always @(posedge clk) begin
        div    <= (div == BDIV - 1) ? 0 : div + 1;
        bit_en <= bit_gate && (div == BDIV - 1);
    end

    // Frame receiver: samples the line in each bit slot.
    always @(negedge clk) begin
        if (rst_n && bit_en) begin
            if (rx_bits == 0) begin
                if (ser_out) rx_bits = 1;
                rx_acc = 0;
            end else begin
                rx_acc = (rx_acc << 1) | int'(ser_out);
                rx_bits++;
                if (rx_bits == 12) begin
                    rx_w[rx_n] = rx_acc;
                    rx_n++;
                    rx_bits = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FIFO FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply one crossing; expected words kept up to 'keep'.
    task automatic do_xing(input logic [127:0] mask, input int keep);
        int kept = 0;
        @(negedge clk);
        strips_in = mask;
        xing_stb  = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (mask[i] && kept < keep) begin
                exp_w[exp_n] = (i << 4) | exp_tag;
                exp_n++;
                kept++;
            end
        end
        exp_tag = (exp_tag + 1) % 16;
        @(negedge clk);
        xing_stb  = 1'b0;
        strips_in = '0;
        wait_cyc(XPER - 2);
    endtask

    task automatic compare(input string req);
        chk(rx_n == exp_n, req, rx_n, exp_n);
        for (int i = cmp_from; i < exp_n && i < rx_n; i++)
            chk(rx_w[i] == exp_w[i], req, rx_w[i], exp_w[i]);
        cmp_from = exp_n;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(ser_out == 1'b0, "R1 ser_out", int'(ser_out), 0);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        chk(drop_count == '0, "R1 drop_count", int'(drop_count), 0);
    endtask

    task automatic t_empty();
        int ones = 0;
        do_xing('0, 100);
        for (int i = 0; i < 3 * XPER; i++) begin
            @(negedge clk);
            if (ser_out) ones++;
        end
        chk(ones == 0, "R2 idle line", ones, 0);
        compare("R2 no frame");
    endtask

    task automatic t_single();
        logic [127:0] m = '0;
        m[0] = 1'b1;
        do_xing(m, 100);
        m = '0; m[99] = 1'b1;
        do_xing(m, 100);
        wait_cyc(2 * XPER);
        compare("R3 word format");
    endtask

    task automatic t_multi();
        logic [127:0] m = '0;
        m[77] = 1'b1; m[3] = 1'b1; m[50] = 1'b1; m[12] = 1'b1; m[98] = 1'b1;
        do_xing(m, 100);
        m = '0; m[60] = 1'b1; m[1] = 1'b1; m[33] = 1'b1;
        do_xing(m, 100);
        wait_cyc(8 * XPER);
        compare("R4 R7 R8 ascending back-to-back");
    endtask

    task automatic t_upper();
        logic [127:0] m = '0;
        for (int i = 100; i < 128; i++) m[i] = 1'b1;
        do_xing(m, 100);
        m[5] = 1'b1;
        do_xing(m, 100);
        wait_cyc(2 * XPER);
        compare("R6 upper lanes");
    endtask

    task automatic t_tag_wrap();
        for (int k = 0; k < 18; k++) begin
            logic [127:0] m = '0;
            m[k * 5] = 1'b1;
            do_xing(m, 100);
        end
        wait_cyc(3 * XPER);
        compare("R5 tag wrap");
    endtask

    task automatic t_overflow();
        logic [127:0] m = '0;
        bit_gate = 1'b0;
        wait_cyc(20);
        for (int i = 0; i < 30; i++) m[i] = 1'b1;
        do_xing(m, 16);
        chk(overflow == 1'b1, "R9 overflow set", int'(overflow), 1);
        chk(int'(drop_count) == 14, "R9 drop count", int'(drop_count), 14);
        m = '0;
        for (int i = 40; i < 50; i++) m[i] = 1'b1;
        do_xing(m, 0);
        chk(int'(drop_count) == 15, "R9 drop saturate", int'(drop_count), 15);
        bit_gate = 1'b1;
        wait_cyc(17 * XPER + 200);
        compare("R8 R9 stored sixteen");
        chk(overflow == 1'b1, "R9 overflow sticky", int'(overflow), 1);
        chk(int'(drop_count) == 15, "R9 count held", int'(drop_count), 15);
    endtask

    initial begin
        t_reset();
        t_empty();
        t_single();
        t_multi();
        t_upper();
        t_tag_wrap();
        t_overflow();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule